// File: doc/BRIEF.md
# Reference Clock Gating Controller

This block decides, on every bus-clock edge, which reference clocks of a multi-mode clock generator are running or gated. It takes these inputs: the software enable bits for the internal and external references, their keep-alive-in-stop bits, the loop reference select, the low-power bit, a 3-bit operating-mode code and a stop request. From them it produces six registered enables. Two are gates for the auxiliary internal and external reference clock outputs. Two are run enables for the internal and external reference oscillators. The last two are an enable for the frequency-locked / phase-locked loop and a flag that says the loop is being fed from the external reference.

Outside stop, an oscillator runs whenever software enables its auxiliary output, the operating mode clocks from it, or the active loop takes it as its reference. When a stop request is sampled, every clock that is not qualified to stay alive is dropped on that same edge, and the loop is turned off. Whether the external reference stays alive depends on its keep-alive bits and also on the operating mode. When the stop request clears, the enables are computed again from the register bits, so an unchanged configuration comes back exactly as it was before stop.

The loop enable follows the mode class. Engaged modes always run the loop. Bypass modes run it unless the low-power bit is set, which lets software let the loop acquire lock before it selects an engaged mode.

Top module: `refclk_gate_ctrl`

## Requirements
- R1: While `rst` is high, every output is 0 on each clock edge except `int_osc_run`, which is 1.
- R2: Outside stop, `int_clk_gate` equals `int_en`.
- R3: During stop, `int_clk_gate` and `int_osc_run` are both equal to `int_en & int_stop_en`.
- R4: Outside stop, `ext_clk_gate` equals `ext_en`.
- R5: During stop, `ext_osc_run` is 1 when `ext_en & ext_stop_en` holds or when the mode code is 1, 3, 4, 5 or 7 (the modes that clock from the external reference). `ext_clk_gate` is `ext_en & ext_osc_run`.
- R6: `loop_src_ext` is 1 only when the loop is enabled and `ref_sel_int` is 0. When `ref_sel_int` is 1, the external reference never feeds the loop.
- R7: Outside stop, `loop_en` depends on the mode code (0 FEI, 1 FEE, 2 FBI, 3 FBE, 4 PEE, 5 PBE, 6 BLPI, 7 BLPE). It is 1 for the engaged codes 0, 1 and 4, whatever `low_pwr` holds. It is `!low_pwr` for the bypass codes 2, 3 and 5, and 0 for the low-power codes 6 and 7.
- R8: During stop, `loop_en` and `loop_src_ext` are 0.
- R9: Outside stop, `int_osc_run` is `int_en`, or mode code 0, 2 or 6, or (`loop_en` and `ref_sel_int`). `ext_osc_run` is `ext_en`, or mode code 1, 3, 4, 5 or 7, or (`loop_en` and not `ref_sel_int`).
- R10: Every output reflects the inputs sampled at the previous rising edge. After stop is released with the register bits unchanged, the outputs return to their values from before stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| int_en | input | 1 | Internal reference auxiliary output enable |
| int_stop_en | input | 1 | Keep internal reference alive in stop |
| ext_en | input | 1 | External reference auxiliary output enable |
| ext_stop_en | input | 1 | Keep external reference alive in stop |
| ref_sel_int | input | 1 | Loop reference select: 1 internal, 0 external |
| low_pwr | input | 1 | Disable the loop in bypass modes |
| mode | input | 3 | Operating-mode code |
| stop_req | input | 1 | Stop-mode request |
| int_clk_gate | output | 1 | Gate for the auxiliary internal reference output |
| int_osc_run | output | 1 | Internal reference oscillator run enable |
| ext_clk_gate | output | 1 | Gate for the auxiliary external reference output |
| ext_osc_run | output | 1 | External reference oscillator run enable |
| loop_en | output | 1 | FLL/PLL enable |
| loop_src_ext | output | 1 | Loop is fed from the external reference |

## Verification
The bench builds the block with its default 3-bit mode field. With that width, all eight operating modes are reachable, and the bench sweeps all 1024 combinations of register bits, mode and stop request against an independent model. On top of the sweep, it runs directed sequences. These enter stop and leave it with the configuration held, change the mode while in stop, and assert reset in the middle of a run. Those sequences cover the pre-stop restore and the reset values.

// File: rtl/refgate_pkg.sv
package refgate_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_FEI  = 3'd0,
    MD_FEE  = 3'd1,
    MD_FBI  = 3'd2,
    MD_FBE  = 3'd3,
    MD_PEE  = 3'd4,
    MD_PBE  = 3'd5,
    MD_BLPI = 3'd6,
    MD_BLPE = 3'd7
  } op_mode_e;

  typedef struct packed {
    logic int_gate;
    logic int_run;
    logic ext_gate;
    logic ext_run;
    logic loop_on;
    logic loop_ext;
  } gate_vec_t;

  localparam int GATE_W = $bits(gate_vec_t);

  // only the internal oscillator runs out of reset
  localparam gate_vec_t GATE_RST = '{int_gate: 1'b0, int_run: 1'b1, ext_gate: 1'b0,
                                     ext_run: 1'b0, loop_on: 1'b0, loop_ext: 1'b0};
endpackage

// File: rtl/refgate_mode_dec.sv
module refgate_mode_dec
  import refgate_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic [MW-1:0] mode,
  output logic          src_int,
  output logic          src_ext,
  output logic          engaged,
  output logic          bypass
);
  always_comb begin
    src_int = 1'b0;
    src_ext = 1'b0;
    engaged = 1'b0;
    bypass  = 1'b0;
    case (op_mode_e'(mode))
      MD_FEI:  begin src_int = 1'b1; engaged = 1'b1; end
      MD_FEE:  begin src_ext = 1'b1; engaged = 1'b1; end
      MD_FBI:  begin src_int = 1'b1; bypass  = 1'b1; end
      MD_FBE:  begin src_ext = 1'b1; bypass  = 1'b1; end
      MD_PEE:  begin src_ext = 1'b1; engaged = 1'b1; end
      MD_PBE:  begin src_ext = 1'b1; bypass  = 1'b1; end
      MD_BLPI: src_int = 1'b1;
      MD_BLPE: src_ext = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/refgate_policy.sv
module refgate_policy
  import refgate_pkg::*;
(
  input  logic      int_en,
  input  logic      int_stop_en,
  input  logic      ext_en,
  input  logic      ext_stop_en,
  input  logic      ref_sel_int,
  input  logic      low_pwr,
  input  logic      stop_req,
  input  logic      src_int,
  input  logic      src_ext,
  input  logic      engaged,
  input  logic      bypass,
  output gate_vec_t next_v
);
  gate_vec_t run_v;
  gate_vec_t stop_v;
  logic      loop_req;
  logic      ext_alive;

  // run state
  always_comb begin
    loop_req         = engaged | (bypass & ~low_pwr);
    run_v.int_gate   = int_en;
    run_v.ext_gate   = ext_en;
    run_v.loop_on    = loop_req;
    run_v.loop_ext   = loop_req & ~ref_sel_int;
    run_v.int_run    = int_en | src_int | (loop_req & ref_sel_int);
    run_v.ext_run    = ext_en | src_ext | (loop_req & ~ref_sel_int);
  end

  // stop state: only qualified clocks survive
  always_comb begin
    ext_alive        = (ext_en & ext_stop_en) | src_ext;
    stop_v.int_gate  = int_en & int_stop_en;
    stop_v.int_run   = int_en & int_stop_en;
    stop_v.ext_run   = ext_alive;
    stop_v.ext_gate  = ext_en & ext_alive;
    stop_v.loop_on   = 1'b0;
    stop_v.loop_ext  = 1'b0;
  end

  assign next_v = stop_req ? stop_v : run_v;
endmodule

// File: rtl/refgate_outreg.sv
module refgate_outreg #(
  parameter int           W       = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= RST_VAL[i];
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/refclk_gate_ctrl.sv
module refclk_gate_ctrl
  import refgate_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          int_en,
  input  logic          int_stop_en,
  input  logic          ext_en,
  input  logic          ext_stop_en,
  input  logic          ref_sel_int,
  input  logic          low_pwr,
  input  logic [MW-1:0] mode,
  input  logic          stop_req,
  output logic          int_clk_gate,
  output logic          int_osc_run,
  output logic          ext_clk_gate,
  output logic          ext_osc_run,
  output logic          loop_en,
  output logic          loop_src_ext
);
  logic      src_int, src_ext, engaged, bypass;
  gate_vec_t next_v;
  gate_vec_t cur_v;

  refgate_mode_dec #(.MW(MW)) u_dec (
    .mode    (mode),
    .src_int (src_int),
    .src_ext (src_ext),
    .engaged (engaged),
    .bypass  (bypass)
  );

  refgate_policy u_pol (
    .int_en      (int_en),
    .int_stop_en (int_stop_en),
    .ext_en      (ext_en),
    .ext_stop_en (ext_stop_en),
    .ref_sel_int (ref_sel_int),
    .low_pwr     (low_pwr),
    .stop_req    (stop_req),
    .src_int     (src_int),
    .src_ext     (src_ext),
    .engaged     (engaged),
    .bypass      (bypass),
    .next_v      (next_v)
  );

  refgate_outreg #(.W(GATE_W), .RST_VAL(GATE_RST)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (next_v),
    .q   (cur_v)
  );

  assign int_clk_gate = cur_v.int_gate;
  assign int_osc_run  = cur_v.int_run;
  assign ext_clk_gate = cur_v.ext_gate;
  assign ext_osc_run  = cur_v.ext_run;
  assign loop_en      = cur_v.loop_on;
  assign loop_src_ext = cur_v.loop_ext;
endmodule

// File: rtl/refclk_gate_ctrl_chk.sv
module refclk_gate_ctrl_chk #(
  parameter int MW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          int_en,
  input logic          int_stop_en,
  input logic          ext_en,
  input logic          ext_stop_en,
  input logic          ref_sel_int,
  input logic          low_pwr,
  input logic [MW-1:0] mode,
  input logic          stop_req,
  input logic          int_clk_gate,
  input logic          int_osc_run,
  input logic          ext_clk_gate,
  input logic          ext_osc_run,
  input logic          loop_en,
  input logic          loop_src_ext
);
  logic ext_mode, eng_mode;
  assign ext_mode = (mode == 3'd1) || (mode == 3'd3) || (mode == 3'd4) ||
                    (mode == 3'd5) || (mode == 3'd7);
  assign eng_mode = (mode == 3'd0) || (mode == 3'd1) || (mode == 3'd4);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (int_osc_run && !int_clk_gate && !ext_clk_gate && !ext_osc_run && !loop_en && !loop_src_ext)); // R1

  AST_INT_GATE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
    !stop_req |=> (int_clk_gate == $past(int_en))); // R2

  AST_INT_STOP_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !(int_en && int_stop_en)) |=> (!int_osc_run && !int_clk_gate)); // R3

  AST_EXT_GATE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
    !stop_req |=> (ext_clk_gate == $past(ext_en))); // R4

  AST_EXT_ALIVE_IN_STOP: assert property (@(posedge clk) disable iff (rst)
    (stop_req && ext_mode) |=> ext_osc_run); // R5

  AST_NO_EXT_TO_LOOP: assert property (@(posedge clk) disable iff (rst)
    ref_sel_int |=> !loop_src_ext); // R6

  AST_ENGAGED_LOOP_ON: assert property (@(posedge clk) disable iff (rst)
    (!stop_req && eng_mode) |=> loop_en); // R7

  AST_STOP_LOOP_OFF: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> (!loop_en && !loop_src_ext)); // R8

  AST_SRC_IMPLIES_LOOP: assert property (@(posedge clk) disable iff (rst)
    loop_src_ext |-> loop_en); // R6
endmodule

bind refclk_gate_ctrl refclk_gate_ctrl_chk #(.MW(MW)) u_chk (.*);

// File: tb/refclk_gate_ctrl_tb.sv
module refclk_gate_ctrl_tb;
  localparam int  CLK_PERIOD = 10;
  localparam int  WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst;
  logic       int_en, int_stop_en, ext_en, ext_stop_en, ref_sel_int, low_pwr, stop_req;
  logic [2:0] mode;
  logic       int_clk_gate, int_osc_run, ext_clk_gate, ext_osc_run, loop_en, loop_src_ext;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [5:0] exp;   // {int_gate,int_run,ext_gate,ext_run,loop,src_ext}
    bit         stp;
    string      tag;   // overrides per-output tag when non-empty
  } item_t;

  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_gate_ctrl u_dut (
    .clk(clk), .rst(rst), .int_en(int_en), .int_stop_en(int_stop_en),
    .ext_en(ext_en), .ext_stop_en(ext_stop_en), .ref_sel_int(ref_sel_int),
    .low_pwr(low_pwr), .mode(mode), .stop_req(stop_req),
    .int_clk_gate(int_clk_gate), .int_osc_run(int_osc_run),
    .ext_clk_gate(ext_clk_gate), .ext_osc_run(ext_osc_run),
    .loop_en(loop_en), .loop_src_ext(loop_src_ext)
  );

  function automatic logic [5:0] model();
    logic ig, ir, eg, er, lp, lx, xm, im, loop;
    xm   = mode inside {3'd1, 3'd3, 3'd4, 3'd5, 3'd7};
    im   = !xm;
    if (mode inside {3'd0, 3'd1, 3'd4})      loop = 1'b1;   // R7 engaged
    else if (mode inside {3'd2, 3'd3, 3'd5}) loop = !low_pwr;
    else                                      loop = 1'b0;
    if (rst) return 6'b010000;                              // R1
    if (stop_req) begin
      ig = int_en & int_stop_en;                            // R3
      ir = ig;
      er = (ext_en & ext_stop_en) | xm;                     // R5
      eg = ext_en & er;
      lp = 1'b0;                                            // R8
      lx = 1'b0;
    end else begin
      ig = int_en;                                          // R2
      eg = ext_en;                                          // R4
      lp = loop;
      lx = loop & !ref_sel_int;                             // R6
      ir = int_en | im | (loop & ref_sel_int);              // R9
      er = ext_en | xm | (loop & !ref_sel_int);
    end
    return {ig, ir, eg, er, lp, lx};
  endfunction

  // driver: applies at the falling edge, pushes the expected result of the next rising edge
  task automatic drive(input logic [9:0] cfg, input string tag = "");
    item_t it;
    @(negedge clk);
    {int_en, int_stop_en, ext_en, ext_stop_en, ref_sel_int, low_pwr, mode, stop_req} = cfg;
    it.exp = model();
    it.stp = stop_req;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  function automatic logic [9:0] cur_cfg();
    return {int_en, int_stop_en, ext_en, ext_stop_en, ref_sel_int, low_pwr, mode, stop_req};
  endfunction

  function automatic string out_tag(int idx, bit stp);
    case (idx)
      5: return stp ? "R3" : "R2";
      4: return stp ? "R3" : "R9";
      3: return stp ? "R5" : "R4";
      2: return stp ? "R5" : "R9";
      1: return stp ? "R8" : "R7";
      default: return stp ? "R8" : "R6";
    endcase
  endfunction

  // monitor: samples one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      logic [5:0] got;
      it  = sbq.pop_front();
      got = {int_clk_gate, int_osc_run, ext_clk_gate, ext_osc_run, loop_en, loop_src_ext};
      n_vec++;
      for (int i = 0; i < 6; i++) begin
        if (got[i] !== it.exp[i]) begin
          n_fail++;
          $display("FAIL %s output bit %0d: got %b expected %b",
                   (it.tag != "") ? it.tag : out_tag(i, it.stp), i, got[i], it.exp[i]);
        end
      end
    end
  end

  initial begin
    logic [9:0] keep;
    logic [5:0] pre;
    rst = 1'b1;
    {int_en, int_stop_en, ext_en, ext_stop_en, ref_sel_int, low_pwr, mode, stop_req} = '0;
    // R1: reset state, with reset held while inputs request everything
    drive(10'h000, "R1");
    rst = 1'b1;
    drive(10'h3FE, "R1");
    drive(10'h3FF, "R1");
    @(negedge clk);
    rst = 1'b0;
    // exhaustive sweep R2..R9, R10 per-edge timing
    for (int c = 0; c < 1024; c++) drive(c[9:0]);
    // R10: stop entry/exit restores pre-stop values
    for (int m = 0; m < 8; m++) begin
      keep = {6'b101110, m[2:0], 1'b0};
      drive(keep, "R10");
      drive(keep, "R10");
      @(posedge clk); #2;
      pre = {int_clk_gate, int_osc_run, ext_clk_gate, ext_osc_run, loop_en, loop_src_ext};
      drive(keep | 10'd1, "R10");
      drive(keep | 10'd1, "R10");
      drive(keep, "R10");
      @(posedge clk); #2;
      n_vec++;
      if ({int_clk_gate, int_osc_run, ext_clk_gate, ext_osc_run, loop_en, loop_src_ext} !== pre) begin
        n_fail++;
        $display("FAIL R10 restore mode %0d: got %b expected %b", m,
                 {int_clk_gate, int_osc_run, ext_clk_gate, ext_osc_run, loop_en, loop_src_ext}, pre);
      end
    end
    // mode change while stopped, then release (R5, R10)
    drive({6'b001000, 3'd0, 1'b1});
    drive({6'b001000, 3'd7, 1'b1}, "R5");
    drive({6'b001000, 3'd7, 1'b0}, "R10");
    // R6: loop engaged on internal reference never takes the external one
    drive({6'b001010, 3'd4, 1'b0}, "R6");
    drive({6'b001000, 3'd4, 1'b0}, "R6");
    // R7: low-power bit in engaged vs bypass
    drive({6'b000001, 3'd1, 1'b0}, "R7");
    drive({6'b000001, 3'd5, 1'b0}, "R7");
    drive({6'b000000, 3'd5, 1'b0}, "R7");
    // mid-run reset
    @(negedge clk);
    rst = 1'b1;
    drive(cur_cfg(), "R1");
    @(negedge clk);
    rst = 1'b0;
    drive(10'h000);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule